// File: doc/BRIEF.md
# Vector Mask Operand Address Generator

This block produces the register-file read addresses that fetch the mask register v0 from one lane of a banked vector register file. A masked vector instruction carries one mask bit per element. That mask always lives in v0, whatever the register grouping of the data operands. A start request supplies four values: the lane's first element index, the element-width code, the lane's element count and the entry of v0 within the banks. The block then issues one word address at a time on a valid/ready port. Each address is a bank select plus an entry inside that bank.

A 64-bit register-file word holds 64 mask bits. The first word to fetch is therefore the lane start index divided by 64, whatever the element width. The datapath first forms the element-data word offset, start >> (3 − width code). It then narrows that to mask-bit granularity with a further right shift by (3 + width code). A large start index thus moves the access to a higher bank of v0 and never into a later register. Words are issued in ascending order up to the word that holds the bit of the lane's last element. The block then goes idle.

Top module: `mask_addr_gen`

## Requirements
- R1: After reset, reqReady is 1 and addrValid is 0.
- R2: The bank of the first address is bits [2:0] of (reqStart >> 6). The width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit elements) does not change it.
- R3: Every address of a request carries addrEntry equal to the reqBase given with that request, so the access never leaves v0. For example, start 511 with width code 0 and element count 512 reads bank 7 at the v0 entry.
- R4: Addresses go out in consecutive banks, one per accepted handshake, ending with the word (reqVl − 1) >> 6. After that word is accepted, reqReady returns to 1.
- R5: A request with reqVl = 0, or with reqStart ≥ reqVl, is accepted and issues no address, and reqReady stays 1.
- R6: While addrValid is 1 and addrReady is 0, addrValid stays 1 and addrBank and addrEntry hold their values.
- R7: reqReady is 0 while a request is in progress. A reqValid presented then is ignored and does not disturb the running address sequence.
- R8: Start 448 with element count 512 issues exactly one address, at bank 7. No lower bank of v0 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Start request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqStart | input | VlW | Lane starting element index |
| reqSew | input | 2 | Element-width code |
| reqVl | input | VlW | Element count for this lane |
| reqBase | input | EntryW | Entry of v0 within the banks |
| addrValid | output | 1 | Word address present |
| addrReady | input | 1 | Consumer takes the word address |
| addrBank | output | BankW | Bank select of the word address |
| addrEntry | output | EntryW | Entry within the bank |

## Verification
The hardest situation to reach is a request that arrives while a sequence is in flight. It must be ignored, and the proof must come from the ports alone. The stimulus keeps reqValid high with different fields just after a request is accepted. It then checks that reqReady is low and that the bank sequence and entry still follow the first request. Stalls on the address port are forced on multi-word requests so that the held-output rule is exercised part-way through a sequence. The same start and length are run under several width codes to show that the mask word does not depend on element size.

// File: rtl/maskag_pkg.sv
package maskag_pkg;
  typedef struct packed {
    logic load;     // capture a non-empty request
    logic advance;  // move to the next mask word
  } ctlStrobes_t;
endpackage

// File: rtl/maskag_dpath.sv
module maskag_dpath
  import maskag_pkg::*;
#(
  parameter int VlW       = 10,
  parameter int EntryW    = 5,
  parameter int BankW     = 3,
  parameter int WordShift = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [VlW-1:0]    reqStart,
  input  logic [1:0]        reqSew,
  input  logic [VlW-1:0]    reqVl,
  input  logic [EntryW-1:0] reqBase,
  output logic              reqEmpty,
  output logic              isLast,
  output logic [BankW-1:0]  addrBank,
  output logic [EntryW-1:0] addrEntry
);
  localparam int ByteShift = WordShift - 3;

  logic [VlW-1:0]    elemWord, startWord, lastWordIn;
  logic [VlW-1:0]    curWord, lastWord;
  logic [EntryW-1:0] baseEntry;
  logic [2:0]        elemShift, maskShift;

  always_comb begin
    elemShift  = 3'(ByteShift) - {1'b0, reqSew};
    maskShift  = 3'(WordShift - ByteShift) + {1'b0, reqSew};
    elemWord   = reqStart >> elemShift;
    startWord  = elemWord >> maskShift;
    lastWordIn = (reqVl - VlW'(1)) >> WordShift;
    reqEmpty   = (reqVl == '0) || (reqStart >= reqVl);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord   <= '0;
      lastWord  <= '0;
      baseEntry <= '0;
    end else if (strobes.load) begin
      curWord   <= startWord;
      lastWord  <= lastWordIn;
      baseEntry <= reqBase;
    end else if (strobes.advance) begin
      curWord   <= curWord + VlW'(1);
    end
  end

  assign isLast    = (curWord == lastWord);
  assign addrBank  = curWord[BankW-1:0];
  assign addrEntry = baseEntry + EntryW'(curWord >> BankW);

  assert_bank_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> addrBank == $past(addrBank) + BankW'(1));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.load) |=> ($stable(addrBank) && $stable(addrEntry)));
endmodule

// File: rtl/maskag_ctrl.sv
module maskag_ctrl
  import maskag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqEmpty,
  input  logic        isLast,
  input  logic        addrReady,
  output logic        reqReady,
  output logic        addrValid,
  output ctlStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state, stateNext;

  always_comb begin
    strobes.load    = (state == ST_IDLE) && reqValid && !reqEmpty;
    strobes.advance = (state == ST_BUSY) && addrReady && !isLast;
    stateNext = state;
    case (state)
      ST_IDLE: if (strobes.load) stateNext = ST_BUSY;
      ST_BUSY: if (addrReady && isLast) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady  = (state == ST_IDLE);
  assign addrValid = (state == ST_BUSY);

  assert_finish_R4: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && addrReady && isLast) |=> reqReady);

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> addrValid);

  assert_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && reqEmpty) |=> (reqReady && !addrValid));
endmodule

// File: rtl/mask_addr_gen.sv
module mask_addr_gen
  import maskag_pkg::*;
#(
  parameter int MaxLaneVl   = 512,
  parameter int MaskWordBit = 64,
  parameter int NumBanks    = 8,
  parameter int EntryW      = 5,
  localparam int VlW        = $clog2(MaxLaneVl + 1),
  localparam int BankW      = $clog2(NumBanks)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VlW-1:0]    reqStart,
  input  logic [1:0]        reqSew,
  input  logic [VlW-1:0]    reqVl,
  input  logic [EntryW-1:0] reqBase,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [BankW-1:0]  addrBank,
  output logic [EntryW-1:0] addrEntry
);
  localparam int WordShift = $clog2(MaskWordBit);

  ctlStrobes_t strobes;
  logic        reqEmpty, isLast;

  maskag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEmpty(reqEmpty),
    .isLast(isLast), .addrReady(addrReady), .reqReady(reqReady),
    .addrValid(addrValid), .strobes(strobes)
  );

  maskag_dpath #(.VlW(VlW), .EntryW(EntryW), .BankW(BankW), .WordShift(WordShift)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqStart(reqStart),
    .reqSew(reqSew), .reqVl(reqVl), .reqBase(reqBase), .reqEmpty(reqEmpty),
    .isLast(isLast), .addrBank(addrBank), .addrEntry(addrEntry)
  );

  assert_v0_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && $past(addrValid)) |-> $stable(addrEntry));

  assert_busy_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> !reqReady);
endmodule

// File: tb/sim_mask_addr_gen.sv
module sim_mask_addr_gen;
  typedef struct packed {
    logic [9:0] start;
    logic [1:0] sew;
    logic [9:0] vl;
    logic [4:0] base;
    logic [3:0] first;
    logic [3:0] count;
    logic       stall;
    logic       intrude;
  } vec_t;

  localparam int NumVec = 12;
  localparam vec_t Vecs [NumVec] = '{
    '{10'd0,   2'd0, 10'd512, 5'd0,  4'd0, 4'd8, 1'b0, 1'b0},
    '{10'd511, 2'd0, 10'd512, 5'd0,  4'd7, 4'd1, 1'b0, 1'b0}, // R3 example
    '{10'd448, 2'd3, 10'd512, 5'd5,  4'd7, 4'd1, 1'b0, 1'b0}, // R8
    '{10'd100, 2'd1, 10'd300, 5'd2,  4'd1, 4'd4, 1'b0, 1'b0}, // R2
    '{10'd100, 2'd3, 10'd300, 5'd2,  4'd1, 4'd4, 1'b1, 1'b0}, // R2, R6
    '{10'd100, 2'd2, 10'd300, 5'd9,  4'd1, 4'd4, 1'b0, 1'b1}, // R2, R7
    '{10'd64,  2'd2, 10'd65,  5'd1,  4'd1, 4'd1, 1'b0, 1'b0},
    '{10'd63,  2'd0, 10'd64,  5'd4,  4'd0, 4'd1, 1'b0, 1'b0},
    '{10'd0,   2'd3, 10'd1,   5'd31, 4'd0, 4'd1, 1'b1, 1'b0},
    '{10'd0,   2'd0, 10'd0,   5'd3,  4'd0, 4'd0, 1'b0, 1'b0}, // R5
    '{10'd300, 2'd1, 10'd300, 5'd3,  4'd0, 4'd0, 1'b0, 1'b0}, // R5
    '{10'd200, 2'd2, 10'd512, 5'd3,  4'd3, 4'd5, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [9:0] reqStart = '0;
  logic [1:0] reqSew = '0;
  logic [9:0] reqVl = '0;
  logic [4:0] reqBase = '0;
  logic       addrValid;
  logic       addrReady = 1'b0;
  logic [2:0] addrBank;
  logic [4:0] addrEntry;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  mask_addr_gen u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqStart(reqStart), .reqSew(reqSew), .reqVl(reqVl), .reqBase(reqBase),
    .addrValid(addrValid), .addrReady(addrReady), .addrBank(addrBank),
    .addrEntry(addrEntry)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runVec(input int idx);
    vec_t v = Vecs[idx];
    int got = 0;
    logic [2:0] held;
    string seqTag = (v.count == 0) ? "R5" : ((v.start == 10'd448) ? "R8" : "R4");
    @(negedge clk);
    chk(reqReady == 1'b1, "R7 idle ready", int'(reqReady), 1);
    reqValid = 1'b1; reqStart = v.start; reqSew = v.sew; reqVl = v.vl; reqBase = v.base;
    addrReady = !v.stall;
    @(negedge clk);
    reqValid = 1'b0;
    if (v.intrude) begin
      reqValid = 1'b1; reqStart = 10'd0; reqSew = 2'd0; reqVl = 10'd512; reqBase = 5'd17;
      chk(reqReady == 1'b0, "R7 busy not ready", int'(reqReady), 0);
    end
    if (v.stall && v.count != 0) begin
      held = addrBank;
      @(negedge clk);
      chk(addrValid == 1'b1, "R6 valid held", int'(addrValid), 1);
      chk(addrBank == held, "R6 bank held", int'(addrBank), int'(held));
      @(negedge clk);
      chk(addrBank == held && addrEntry == v.base, "R6 addr held", int'(addrBank), int'(held));
      addrReady = 1'b1;
    end
    for (int k = 0; k < 16; k++) begin
      if (!addrValid) break;
      chk(addrBank == 3'(v.first + got), (got == 0) ? "R2 first bank" : "R4 bank step",
          int'(addrBank), int'(3'(v.first + got)));
      chk(addrEntry == v.base, "R3 entry is v0", int'(addrEntry), int'(v.base));
      got++;
      @(negedge clk);
      reqValid = 1'b0;
    end
    chk(got == int'(v.count), seqTag, got, int'(v.count));
    chk(reqReady == 1'b1 && addrValid == 1'b0, "R4 back to idle", int'(reqReady), 1);
    reqValid = 1'b0;
    addrReady = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1 reset ready", int'(reqReady), 1);
    chk(addrValid == 1'b0, "R1 reset valid", int'(addrValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && addrValid == 1'b0, "R1 after release", int'(addrValid), 0);
    for (int i = 0; i < NumVec; i++) runVec(i);
    // R2: same start under every width code gives the same single word
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      reqValid = 1'b1; reqStart = 10'd320; reqSew = 2'(s); reqVl = 10'd330; reqBase = 5'd6;
      addrReady = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      chk(addrValid && addrBank == 3'd5, "R2 width independent", int'(addrBank), 5);
      @(negedge clk);
      chk(!addrValid, "R4 single word", int'(addrValid), 0);
      addrReady = 1'b0;
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule